// File: doc/BRIEF.md
# DMA Block Transfer Channel Sequencer

This block sequences one DMA channel in block mode. After the channel is armed, each accepted transfer request moves a whole block of transfers. A transfer is a byte or a word, copied from a source address to a destination address. The block size is programmable from 1 to 256. Every transfer uses two bus cycles: a read cycle that captures data into a holding register, then a write cycle that puts the captured value out. The channel asks for the bus with a request/grant handshake and keeps it for the whole block. At the end of the block it releases the bus at once.

A 24-bit count word is loaded when the channel is armed. The block size is in its upper byte, and a 16-bit count of the blocks still to run is in its lower half. The source and destination address counters each step on their own: they stay fixed, count up or count down. They carry their values from one block into the next and are not restored. While a block runs, a request from a higher-priority channel is not acknowledged. An optional yield setting lets another bus master take the bus between two transfers. The channel finishes the block once it has the bus again. When the block count runs out, the channel disarms itself and raises a completion flag.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset, bus_req, xfer_ack, blk_end, mem_rd, mem_wr, chan_en and done_irq are all low.
- R2: The block size is cfg_count[23:16], and a value of 0 means 256. One accepted request produces exactly that many transfers.
- R3: Each transfer is a read cycle (mem_rd) at the source address, followed in the next clock cycle by a write cycle (mem_wr) at the destination address. The write carries the data read. In byte mode (cfg_word=0) the data is mem_rdata[7:0], zero-extended.
- R4: After each transfer, each address steps according to its 2-bit mode: 00 or 11 keeps it fixed, 01 adds the step, 10 subtracts the step. The step is 1 in byte mode and 2 in word mode. Addresses continue across blocks without being restored.
- R5: blk_end is high only during the write cycle of the last transfer of a block, so it is high exactly once per block.
- R6: xfer_ack is a single-cycle pulse, given once for each accepted request. A request is accepted only while the channel is armed and idle, and only when hp_req is low in that cycle.
- R7: bus_req is low in the cycle right after the write cycle that carries blk_end.
- R8: hp_ack stays low while a block is in progress. It goes high for a held hp_req in the first cycle after the block ends.
- R9: With cfg_giveup=1, if other_req is high during a write cycle that is not the last of the block, bus_req drops until other_req falls. The channel then asks for the bus again and runs the remaining transfers. With cfg_giveup=0, other_req has no effect on a block.
- R10: xfer_left is loaded from cfg_count[15:0] and decrements at each block end. When it reaches 0, chan_en clears and done_irq sets. After that, requests get no xfer_ack and start no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Arms the channel and loads all settings below |
| cfg_count | input | 24 | Block size [23:16] (0 = 256), block count [15:0] |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_smode | input | 2 | Source step mode: 00/11 fixed, 01 up, 10 down |
| cfg_dmode | input | 2 | Destination step mode, same coding |
| cfg_word | input | 1 | 1 = word transfers (step 2), 0 = byte (step 1) |
| cfg_giveup | input | 1 | Allow yielding the bus to another master mid-block |
| xfer_req | input | 1 | Transfer request for this channel |
| xfer_ack | output | 1 | Request accepted pulse |
| hp_req | input | 1 | Request pending on a higher-priority channel |
| hp_ack | output | 1 | Higher-priority request may be serviced now |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| other_req | input | 1 | Another bus master wants the bus |
| mem_rd | output | 1 | Read bus cycle |
| mem_wr | output | 1 | Write bus cycle |
| mem_addr | output | AW | Bus cycle address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid during the read cycle |
| blk_end | output | 1 | Last transfer of a block |
| chan_en | output | 1 | Channel armed |
| done_irq | output | 1 | Block count exhausted |
| xfer_left | output | 16 | Blocks remaining |

## Verification
The hardest situation to reach is a yield in the middle of a block. It needs the yield setting on, and another master's request must be high in a write cycle that is not the last one. The bench waits a fixed number of cycles after the acknowledge to land inside the block. It holds other_req for several cycles, and its arbiter model withholds the grant while other_req is high. It then checks that the bus request dropped and that the block still moved every transfer in order. The same stimulus with the yield setting off must show no gap. A block size field of 0 is run to confirm the 256-transfer case.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_PAUSE = 3'd4
  } seq_st_t;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_UP    = 2'b01,
    AM_DOWN  = 2'b10,
    AM_HOLD  = 2'b11
  } amode_t;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [1:0]    mode,
  input  logic          word,
  input  logic          step_en,
  output logic [AW-1:0] addr
);
  import dma_blk_pkg::*;

  logic [AW-1:0] addr_q, addr_d, step;

  assign step = {{(AW-2){1'b0}}, word, ~word};

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = load_val;
    end else if (step_en) begin
      case (amode_t'(mode))
        AM_UP:   addr_d = addr_q + step;
        AM_DOWN: addr_d = addr_q - step;
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (load || step_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R4
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && (mode == 2'b00 || mode == 2'b11)) |=> $stable(addr));
endmodule

// File: rtl/dma_blk_cnt.sv
module dma_blk_cnt #(
  parameter int SZW  = 8,
  parameter int CNTW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SZW+CNTW-1:0] load_val,
  input  logic                start,
  input  logic                xfer_done,
  output logic                last_xfer,
  output logic                cnt_last,
  output logic [CNTW-1:0]     cnt_val
);
  localparam int BLW = SZW + 1;

  logic [SZW-1:0]  size_q;
  logic [BLW-1:0]  left_q, left_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else if (load) size_q <= load_val[SZW+CNTW-1:CNTW];
  end

  always_comb begin
    left_d = left_q;
    if (start) begin
      if (size_q == '0) left_d = {1'b1, {SZW{1'b0}}};
      else              left_d = {1'b0, size_q};
    end else if (xfer_done) begin
      left_d = left_q - 1'b1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val[CNTW-1:0];
    else if (xfer_done && last_xfer) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (start || xfer_done) left_q <= left_d;
      if (load || (xfer_done && last_xfer)) cnt_q <= cnt_d;
    end
  end

  assign last_xfer = (left_q == BLW'(1));
  assign cnt_last  = (cnt_q == CNTW'(1));
  assign cnt_val   = cnt_q;

  // R2
  blk_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (left_q != '0));
  // R2
  blk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (left_q != '0));
endmodule

// File: rtl/dma_blk_fsm.sv
module dma_blk_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic giveup,
  input  logic req,
  input  logic hp_req,
  input  logic bus_gnt,
  input  logic other_req,
  input  logic last_xfer,
  input  logic cnt_last,
  output logic accept,
  output logic hp_ack,
  output logic bus_req,
  output logic rd_cyc,
  output logic wr_cyc,
  output logic tend,
  output logic chan_en,
  output logic done_irq
);
  import dma_blk_pkg::*;

  seq_st_t st_q, st_d;
  logic    en_q, en_d, irq_q, irq_d;

  assign accept  = (st_q == ST_IDLE) && en_q && req && !hp_req;
  assign hp_ack  = (st_q == ST_IDLE) && hp_req;
  assign bus_req = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign rd_cyc  = (st_q == ST_RD);
  assign wr_cyc  = (st_q == ST_WR);
  assign tend    = wr_cyc && last_xfer;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_REQ;
      ST_REQ:   if (bus_gnt) st_d = ST_RD;
      ST_RD:    st_d = ST_WR;
      ST_WR: begin
        if (last_xfer)               st_d = ST_IDLE;
        else if (giveup && other_req) st_d = ST_PAUSE;
        else                          st_d = ST_RD;
      end
      ST_PAUSE: if (!other_req) st_d = ST_REQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    en_d  = en_q;
    irq_d = irq_q;
    if (cfg_load) begin
      en_d  = 1'b1;
      irq_d = 1'b0;
    end else if (tend && cnt_last) begin
      en_d  = 1'b0;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign chan_en  = en_q;
  assign done_irq = irq_q;

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc |=> wr_cyc);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tend |=> !bus_req);
  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
  // R8
  hp_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_ack && $past(wr_cyc)) |-> $past(tend));
  // R9
  yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && !$past(tend)) |-> $past(giveup && other_req));
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [23:0]   cfg_count,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [1:0]    cfg_smode,
  input  logic [1:0]    cfg_dmode,
  input  logic          cfg_word,
  input  logic          cfg_giveup,
  input  logic          xfer_req,
  output logic          xfer_ack,
  input  logic          hp_req,
  output logic          hp_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          other_req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          blk_end,
  output logic          chan_en,
  output logic          done_irq,
  output logic [15:0]   xfer_left
);
  localparam int SZW  = 8;
  localparam int CNTW = 16;
  localparam int BW   = 8;

  logic [1:0]    smode_q, dmode_q;
  logic          word_q, giveup_q;
  logic [DW-1:0] hold_q, hold_d;
  logic [AW-1:0] src_a, dst_a;
  logic          accept, last_xfer, cnt_last, rd_cyc, wr_cyc, tend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smode_q  <= 2'b00;
      dmode_q  <= 2'b00;
      word_q   <= 1'b0;
      giveup_q <= 1'b0;
    end else if (cfg_load) begin
      smode_q  <= cfg_smode;
      dmode_q  <= cfg_dmode;
      word_q   <= cfg_word;
      giveup_q <= cfg_giveup;
    end
  end

  always_comb begin
    hold_d = word_q ? mem_rdata : {{(DW-BW){1'b0}}, mem_rdata[BW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (rd_cyc) hold_q <= hold_d;
  end

  dma_blk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .giveup(giveup_q),
    .req(xfer_req), .hp_req(hp_req), .bus_gnt(bus_gnt), .other_req(other_req),
    .last_xfer(last_xfer), .cnt_last(cnt_last), .accept(accept), .hp_ack(hp_ack),
    .bus_req(bus_req), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .tend(tend),
    .chan_en(chan_en), .done_irq(done_irq)
  );

  dma_blk_cnt #(.SZW(SZW), .CNTW(CNTW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val(cfg_count),
    .start(accept), .xfer_done(wr_cyc), .last_xfer(last_xfer),
    .cnt_last(cnt_last), .cnt_val(xfer_left)
  );

  dma_addr_ctr #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val(cfg_src),
    .mode(smode_q), .word(word_q), .step_en(wr_cyc), .addr(src_a)
  );

  dma_addr_ctr #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_val(cfg_dst),
    .mode(dmode_q), .word(word_q), .step_en(wr_cyc), .addr(dst_a)
  );

  assign xfer_ack  = accept;
  assign mem_rd    = rd_cyc;
  assign mem_wr    = wr_cyc;
  assign mem_addr  = wr_cyc ? dst_a : src_a;
  assign mem_wdata = wr_cyc ? hold_q : '0;
  assign blk_end   = tend;

  // R10
  irq_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> ($past(blk_end) && xfer_left == 16'd0));
  // R10
  off_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !xfer_ack);
endmodule

// File: tb/sim_dma_blk_seq.sv
`timescale 1ns/1ps
module sim_dma_blk_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load, cfg_word, cfg_giveup, xfer_req, hp_req, other_req;
  logic [23:0] cfg_count;
  logic [15:0] cfg_src, cfg_dst;
  logic [1:0]  cfg_smode, cfg_dmode;
  logic        xfer_ack, hp_ack, bus_req, bus_gnt, mem_rd, mem_wr;
  logic        blk_end, chan_en, done_irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, xfer_left;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] fdat(logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] nxt(logic [15:0] a, logic [1:0] m, logic w);
    logic [15:0] s;
    s = w ? 16'd2 : 16'd1;
    if (m == 2'b01) return a + s;
    if (m == 2'b10) return a - s;
    return a;
  endfunction

  assign bus_gnt   = bus_req && !other_req;
  assign mem_rdata = mem_rd ? fdat(mem_addr) : 16'h0000;

  dma_blk_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_smode(cfg_smode), .cfg_dmode(cfg_dmode),
    .cfg_word(cfg_word), .cfg_giveup(cfg_giveup), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .hp_req(hp_req), .hp_ack(hp_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .other_req(other_req), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .blk_end(blk_end), .chan_en(chan_en),
    .done_irq(done_irq), .xfer_left(xfer_left)
  );

  // monitor, sampling on the falling edge
  logic        lg_k [1024];
  logic [15:0] lg_a [1024];
  logic [15:0] lg_d [1024];
  int lg_n, ack_n, end_n, rel_bad, gap_n, hp_in_blk;
  logic prev_end, in_blk;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_rd || mem_wr) && lg_n < 1024) begin
        lg_k[lg_n] = mem_wr;
        lg_a[lg_n] = mem_addr;
        lg_d[lg_n] = mem_wr ? mem_wdata : mem_rdata;
        lg_n = lg_n + 1;
      end
      if (xfer_ack) ack_n = ack_n + 1;
      if (prev_end && bus_req) rel_bad = rel_bad + 1;
      if (mem_rd) in_blk = 1'b1;
      if (in_blk && !bus_req) gap_n = gap_n + 1;
      if (in_blk && hp_ack) hp_in_blk = hp_in_blk + 1;
      if (blk_end) begin
        end_n  = end_n + 1;
        in_blk = 1'b0;
      end
      prev_end = blk_end;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    lg_n = 0; ack_n = 0; end_n = 0; rel_bad = 0; gap_n = 0; hp_in_blk = 0;
    prev_end = 1'b0; in_blk = 1'b0;
  endtask

  task automatic load_cfg(logic [23:0] cnt, logic [15:0] s, logic [15:0] d,
                          logic [1:0] sm, logic [1:0] dm, logic w, logic g);
    @(posedge clk); #1;
    cfg_count = cnt; cfg_src = s; cfg_dst = d; cfg_smode = sm; cfg_dmode = dm;
    cfg_word = w; cfg_giveup = g; cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic pulse_req();
    @(posedge clk); #1;
    xfer_req = 1'b1;
    @(posedge clk); #1;
    xfer_req = 1'b0;
  endtask

  task automatic wait_end(int old_end);
    for (int i = 0; i < 2000 && end_n == old_end; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic verify(string tag, int n, logic [15:0] s, logic [15:0] d,
                        logic [1:0] sm, logic [1:0] dm, logic w);
    int bad;
    logic [15:0] e;
    bad = 0;
    chk(lg_n == 2 * n, tag, "bus cycle count", lg_n, 2 * n);
    for (int i = 0; i < n && 2 * i + 1 < lg_n; i++) begin
      e = w ? fdat(s) : {8'h00, fdat(s) & 16'h00FF};
      if (lg_k[2*i] != 1'b0 || lg_a[2*i] != s || lg_k[2*i+1] != 1'b1 ||
          lg_a[2*i+1] != d || lg_d[2*i+1] != e) bad++;
      s = nxt(s, sm, w);
      d = nxt(d, dm, w);
    end
    chk(bad == 0, tag, "transfers out of order or wrong address/data", bad, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!bus_req && !xfer_ack && !blk_end && !mem_rd && !mem_wr, "R1", "bus outputs idle",
        {bus_req, xfer_ack, blk_end, mem_rd, mem_wr}, 0);
    chk(!chan_en && !done_irq, "R1", "channel disarmed", {chan_en, done_irq}, 0);
  endtask

  task automatic t_basic();
    load_cfg({8'd3, 16'd2}, 16'h0100, 16'h0200, 2'b01, 2'b01, 1'b0, 1'b0);
    clr_mon();
    pulse_req();
    wait_end(0);
    verify("R3", 3, 16'h0100, 16'h0200, 2'b01, 2'b01, 1'b0);
    chk(ack_n == 1, "R6", "acknowledges per request", ack_n, 1);
    chk(end_n == 1, "R5", "block end strobes", end_n, 1);
    chk(rel_bad == 0, "R7", "bus held after block end", rel_bad, 0);
    chk(xfer_left == 16'd1 && chan_en, "R10", "count after first block", xfer_left, 1);
    // second block continues from where the first stopped
    clr_mon();
    pulse_req();
    wait_end(0);
    verify("R4", 3, 16'h0103, 16'h0203, 2'b01, 2'b01, 1'b0);
    chk(xfer_left == 16'd0, "R10", "count exhausted", xfer_left, 0);
    chk(!chan_en && done_irq, "R10", "disarm and flag", {chan_en, done_irq}, 2'b01);
    // further request is ignored
    clr_mon();
    pulse_req();
    repeat (10) @(posedge clk);
    #1;
    chk(ack_n == 0 && lg_n == 0, "R10", "request after exhaustion", ack_n + lg_n, 0);
  endtask

  task automatic t_word();
    load_cfg({8'd4, 16'd1}, 16'h0300, 16'h0400, 2'b10, 2'b00, 1'b1, 1'b0);
    clr_mon();
    pulse_req();
    wait_end(0);
    verify("R4", 4, 16'h0300, 16'h0400, 2'b10, 2'b00, 1'b1);
    chk(end_n == 1, "R5", "word block end strobes", end_n, 1);
  endtask

  task automatic t_256();
    load_cfg({8'd0, 16'd1}, 16'h1000, 16'h2000, 2'b01, 2'b11, 1'b0, 1'b0);
    clr_mon();
    pulse_req();
    wait_end(0);
    verify("R2", 256, 16'h1000, 16'h2000, 2'b01, 2'b11, 1'b0);
    chk(end_n == 1 && ack_n == 1, "R2", "one request one block", end_n + ack_n, 2);
  endtask

  task automatic t_hp();
    load_cfg({8'd5, 16'd3}, 16'h0500, 16'h0600, 2'b01, 2'b01, 1'b0, 1'b0);
    clr_mon();
    pulse_req();
    hp_req = 1'b1;
    wait_end(0);
    chk(hp_in_blk == 0, "R8", "higher-priority ack inside block", hp_in_blk, 0);
    chk(hp_ack == 1'b1, "R8", "higher-priority ack after block", hp_ack, 1);
    verify("R8", 5, 16'h0500, 16'h0600, 2'b01, 2'b01, 1'b0);
    // own request blocked while the higher-priority request is held
    clr_mon();
    pulse_req();
    repeat (5) @(posedge clk);
    #1;
    chk(ack_n == 0, "R6", "request accepted under hp_req", ack_n, 0);
    hp_req = 1'b0;
  endtask

  task automatic t_giveup(logic g);
    string tg;
    tg = "R9";
    load_cfg({8'd6, 16'd1}, 16'h0700, 16'h0800, 2'b01, 2'b10, 1'b1, g);
    clr_mon();
    pulse_req();
    repeat (3) @(posedge clk);
    #1;
    other_req = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    other_req = 1'b0;
    wait_end(0);
    if (g) chk(gap_n > 0, tg, "bus yielded mid-block", gap_n, 1);
    else   chk(gap_n == 0, tg, "bus kept without yield setting", gap_n, 0);
    verify(tg, 6, 16'h0700, 16'h0800, 2'b01, 2'b10, 1'b1);
    chk(end_n == 1, tg, "block end after resume", end_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_load = 1'b0; cfg_count = '0; cfg_src = '0; cfg_dst = '0;
    cfg_smode = 2'b00; cfg_dmode = 2'b00; cfg_word = 1'b0; cfg_giveup = 1'b0;
    xfer_req = 1'b0; hp_req = 1'b0; other_req = 1'b0;
    clr_mon();
    repeat (3) @(posedge clk);
    t_reset();
    #1;
    rst_n = 1'b1;
    t_basic();
    t_word();
    t_256();
    t_hp();
    t_giveup(1'b1);
    t_giveup(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule